// File: doc/BRIEF.md
# Video Vertical Sync Detector

This block watches a composite sync stream that has already been sliced from video, with sync active low. The stream is treated as synchronous to a free-running system clock. The block measures how long each low pulse lasts in clock cycles and sorts each pulse into one of two kinds. A broad pulse is a serration pulse of the vertical interval. A narrow pulse is a horizontal sync or equalizing pulse. The first broad pulse of a field marks the start of the vertical interval. The block answers it with an active-low vertical sync pulse of fixed length, plus a one-cycle strobe that is aligned with its leading edge.

Some sources carry no serrations. When the input stays low for longer than a programmable limit, the block forces the same pulse anyway. All time constants are parameters counted in clock cycles, so one block covers several line standards: a higher line rate only needs proportionally smaller constants.

Control is a six-state machine:

- **SEEK_HIGH**: after reset, waits for a high input sample.
- **SEEK_LOW**: waits for the input to go low.
- **MEASURE**: waits for the rising edge that completes the first full pulse; no trigger is possible here.
- **ARMED**: watches for a trigger.
- **PULSE**: drives the output low.
- **HOLD**: locks out triggers until a narrow pulse is seen.

Transitions:

- SEEK_HIGH→SEEK_LOW on a high sample.
- SEEK_LOW→MEASURE on a low sample.
- MEASURE→ARMED on a rising edge.
- ARMED→PULSE on a broad rising edge or on timeout.
- PULSE→HOLD when the width timer expires.
- HOLD→ARMED on the rising edge of a narrow pulse.

Top module: `vsync_detector`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `vsync_n` is 1 and `vsync_start` is 0. After reset, no trigger of any kind occurs until one complete low pulse has been seen that started after a high sample.
- R2: A low pulse whose length in low samples is greater than `BROAD_MIN` is broad. A pulse of exactly `BROAD_MIN` low samples or fewer is narrow.
- R3: When armed, `vsync_n` goes low on the clock edge that takes the first high sample ending a broad pulse.
- R4: When armed, if the input stays low, `vsync_n` goes low on the clock edge that takes the `DEFAULT_DLY`-th consecutive low sample, without waiting for the pulse to end.
- R5: Each vertical pulse keeps `vsync_n` low for exactly `VS_WIDTH` clock cycles, whether it was launched by a broad pulse or by a timeout.
- R6: `vsync_start` is 1 for exactly one cycle: the cycle in which `vsync_n` first reads 0 for each pulse.
- R7: After a pulse is launched, broad pulses and long low levels have no effect on `vsync_n` or `vsync_start`. This holds until the pulse has ended and a narrow pulse has then completed.
- R8: Narrow pulses never launch a vertical pulse, including the equalizing pulses that come before the serrations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| csync_n | input | 1 | Sliced composite sync, low during sync |
| vsync_n | output | 1 | Vertical sync, active low, registered |
| vsync_start | output | 1 | One-cycle strobe on the first low cycle of `vsync_n` |

## Verification
The hardest situation to reach from the ports is the lockout window. It needs a launched pulse that has already ended, followed by more broad pulses and a long low level, all arriving before any narrow pulse. In a normal field, equalizing pulses follow the serrations quickly, so this window never opens by itself. The stimulus therefore builds it directly. It fires on a lone broad pulse, keeps the line high past the pulse width, then sends an overlong low level and three serration-like pulses. Only after that does a single horizontal pulse re-arm the block. The boundary cases are driven the same way: pulses of exactly `BROAD_MIN` and `BROAD_MIN+1` low samples, and a low level that crosses `DEFAULT_DLY`.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    typedef enum logic [2:0] {
        ST_SEEK_HIGH = 3'd0,
        ST_SEEK_LOW  = 3'd1,
        ST_MEASURE   = 3'd2,
        ST_ARMED     = 3'd3,
        ST_PULSE     = 3'd4,
        ST_HOLD      = 3'd5
    } vsd_state_e;

endpackage

// File: rtl/vsd_pulse_meter.sv
module vsd_pulse_meter #(
    parameter int BROAD_MIN   = 794,
    parameter int DEFAULT_DLY = 3250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    output logic rise_o,
    output logic broad_o,
    output logic timeout_o
);

    localparam int LOW_MAX = (DEFAULT_DLY > BROAD_MIN + 1) ? DEFAULT_DLY : BROAD_MIN + 1;
    localparam int CNT_W   = $clog2(LOW_MAX + 1);

    logic [CNT_W-1:0] low_cnt;

    // Counts consecutive low samples, saturating at LOW_MAX.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (csync_n) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_W'(LOW_MAX)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign rise_o    = csync_n && (low_cnt != '0);
    assign broad_o   = (low_cnt > CNT_W'(BROAD_MIN));
    assign timeout_o = !csync_n && (low_cnt >= CNT_W'(DEFAULT_DLY - 1));

    assert_rise_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> $past(!csync_n));

endmodule

// File: rtl/vsd_width_timer.sv
module vsd_width_timer #(
    parameter int VS_WIDTH = 13500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);

    localparam int TW = $clog2(VS_WIDTH + 1);

    logic          run;
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (load_i) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (run) begin
            if (cnt == TW'(VS_WIDTH - 1)) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign done_o = run && (cnt == TW'(VS_WIDTH - 1));

    // The controller must never relaunch while a pulse is being timed (lockout).
    assert_no_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !run);

endmodule

// File: rtl/vsd_ctrl.sv
module vsd_ctrl
    import vsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    input  logic rise_i,
    input  logic broad_i,
    input  logic timeout_i,
    input  logic pulse_done_i,
    output logic fire_o,
    output logic vsync_n,
    output logic vsync_start
);

    vsd_state_e state;
    vsd_state_e nxt;

    assign fire_o = (state == ST_ARMED) && (timeout_i || (rise_i && broad_i));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_SEEK_HIGH: if (csync_n)                 nxt = ST_SEEK_LOW;
            ST_SEEK_LOW:  if (!csync_n)                nxt = ST_MEASURE;
            ST_MEASURE:   if (rise_i)                  nxt = ST_ARMED;
            ST_ARMED:     if (fire_o)                  nxt = ST_PULSE;
            ST_PULSE:     if (pulse_done_i)            nxt = ST_HOLD;
            ST_HOLD:      if (rise_i && !broad_i)      nxt = ST_ARMED;
            default:                                   nxt = ST_SEEK_HIGH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SEEK_HIGH;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsync_n     <= 1'b1;
            vsync_start <= 1'b0;
        end else begin
            vsync_n     <= (nxt != ST_PULSE);
            vsync_start <= fire_o;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (vsync_n && !vsync_start));

    assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_start |=> !vsync_start);

    assert_start_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> vsync_start);

    assert_start_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_start |-> !vsync_n);

    assert_width_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_n) |-> $past(pulse_done_i));

    assert_fire_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_start |-> ($past(state) == ST_ARMED));

endmodule

// File: rtl/vsync_detector.sv
module vsync_detector #(
    parameter int BROAD_MIN   = 794,
    parameter int DEFAULT_DLY = 3250,
    parameter int VS_WIDTH    = 13500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    output logic vsync_n,
    output logic vsync_start
);

    logic rise;
    logic broad;
    logic timeout;
    logic fire;
    logic pulse_done;

    vsd_pulse_meter #(
        .BROAD_MIN  (BROAD_MIN),
        .DEFAULT_DLY(DEFAULT_DLY)
    ) meter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .csync_n  (csync_n),
        .rise_o   (rise),
        .broad_o  (broad),
        .timeout_o(timeout)
    );

    vsd_width_timer #(
        .VS_WIDTH(VS_WIDTH)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(fire),
        .done_o(pulse_done)
    );

    vsd_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .csync_n     (csync_n),
        .rise_i      (rise),
        .broad_i     (broad),
        .timeout_i   (timeout),
        .pulse_done_i(pulse_done),
        .fire_o      (fire),
        .vsync_n     (vsync_n),
        .vsync_start (vsync_start)
    );

endmodule

// File: tb/vsync_detector_tb_top.sv
module vsync_detector_tb_top;

    localparam int BMIN = 16;
    localparam int DLY  = 48;
    localparam int VSW  = 100;
    localparam int LMAX = (DLY > BMIN + 1) ? DLY : BMIN + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csync_n = 1'b0;
    logic vsync_n;
    logic vsync_start;

    int checks = 0;
    int fails = 0;
    int starts = 0;
    int lowrun = 0;
    int last_low = 0;
    int r6_bad = 0;
    bit prev_start = 1'b0;

    // Reference model state
    int  m_phase = 0;
    int  m_low = 0;
    int  m_left = 0;
    bit  exp_vsync_n = 1'b1;
    bit  exp_start = 1'b0;

    always #10 clk = ~clk;

    vsync_detector #(.BROAD_MIN(BMIN), .DEFAULT_DLY(DLY), .VS_WIDTH(VSW)) dut_i (
        .clk(clk), .rst_n(rst_n), .csync_n(csync_n),
        .vsync_n(vsync_n), .vsync_start(vsync_start));

    // Behavioural reference: 0 seek high,1 seek low,2 measure,3 armed,4 pulse,5 hold
    always @(posedge clk) begin
        bit s;
        bit rise;
        bit fire;
        s = csync_n;
        if (!rst_n) begin
            m_phase = 0; m_low = 0; m_left = 0;
            exp_vsync_n = 1'b1; exp_start = 1'b0;
        end else begin
            fire = 1'b0;
            rise = s && (m_low > 0);
            case (m_phase)
                0: if (s) m_phase = 1;
                1: if (!s) m_phase = 2;
                2: if (rise) m_phase = 3;
                3: if (!s && (m_low + 1 >= DLY)) fire = 1'b1;      // R4
                   else if (rise && m_low > BMIN) fire = 1'b1;     // R3, R2
                4: begin
                    m_left = m_left - 1;
                    if (m_left == 0) m_phase = 5;                  // R5
                end
                5: if (rise && m_low <= BMIN) m_phase = 3;         // R7
                default: m_phase = 0;
            endcase
            if (fire) begin
                m_phase = 4;
                m_left = VSW;
            end
            exp_vsync_n = (m_phase != 4);
            exp_start = fire;
            if (s) m_low = 0;
            else if (m_low < LMAX) m_low = m_low + 1;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        checks++;
        if (vsync_n !== exp_vsync_n || vsync_start !== exp_start) begin
            fails++;
            $display("FAIL R1 R3 R4 R5 R7 R8 cycle compare at %0t: vsync_n=%b start=%b expected vsync_n=%b start=%b",
                     $time, vsync_n, vsync_start, exp_vsync_n, exp_start);
        end
        if (vsync_start === 1'b1) starts++;
        if (vsync_start === 1'b1 && (vsync_n !== 1'b0 || prev_start)) r6_bad++;
        prev_start = (vsync_start === 1'b1);
        if (vsync_n === 1'b0) lowrun++;
        else if (lowrun > 0) begin
            last_low = lowrun;
            lowrun = 0;
        end
    end

    task automatic lvl(input logic v, input int n);
        repeat (n) begin
            @(negedge clk);
            csync_n = v;
        end
    endtask

    task automatic pulse(input int lo, input int hi);
        lvl(1'b0, lo);
        lvl(1'b1, hi);
    endtask

    task automatic hlines(input int n);
        repeat (n) pulse(5, 59);
    endtask

    task automatic eqs(input int n);
        repeat (n) pulse(2, 30);
    endtask

    task automatic serrs(input int n);
        repeat (n) pulse(27, 5);
    endtask

    task automatic expect_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic field();
        hlines(4); eqs(6); serrs(6); eqs(6); hlines(6);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        int base;
        lvl(1'b0, 4);
        // R1: reset state
        expect_int("R1 vsync_n during reset", int'(vsync_n), 1);
        expect_int("R1 vsync_start during reset", int'(vsync_start), 0);
        @(negedge clk); rst_n = 1'b1;
        // R1: long low from reset and a broad first pulse must not trigger
        lvl(1'b0, 70); lvl(1'b1, 10); serrs(1); lvl(1'b1, 20);
        expect_int("R1 no trigger before first full pulse", starts, 0);

        // R3, R8: normal field, equalizing pulses ignored, first serration fires
        base = starts;
        hlines(2); eqs(6);
        expect_int("R8 no trigger on equalizing pulses", starts - base, 0);
        serrs(6); eqs(6); hlines(6);
        expect_int("R3 one pulse per normal field", starts - base, 1);
        expect_int("R5 width after normal trigger", last_low, VSW);

        // R2: boundary of classification
        base = starts;
        pulse(BMIN, 40);
        expect_int("R2 pulse of BROAD_MIN samples is narrow", starts - base, 0);
        pulse(BMIN + 1, 40);
        expect_int("R2 pulse of BROAD_MIN+1 samples is broad", starts - base, 1);
        lvl(1'b1, VSW + 10); hlines(3);

        // R4: forced pulse when no serrations arrive
        base = starts;
        eqs(6); lvl(1'b0, 80); hlines(4);
        expect_int("R4 forced pulse on long low", starts - base, 1);
        expect_int("R5 width after forced trigger", last_low, VSW);
        // R4: low of DEFAULT_DLY-1 samples ends as a broad pulse, one trigger
        base = starts;
        pulse(DLY - 1, 40);
        expect_int("R4 low one short of timeout fires once", starts - base, 1);
        lvl(1'b1, VSW + 10); hlines(2);

        // R7: lockout until pulse over and a narrow pulse completes
        base = starts;
        serrs(1);
        lvl(1'b1, VSW + 10);
        lvl(1'b0, 80); lvl(1'b1, 10); serrs(3); lvl(1'b1, 20);
        expect_int("R7 broad pulses and long low ignored in hold", starts - base, 1);
        hlines(1); serrs(1); lvl(1'b1, VSW + 10);
        expect_int("R7 re-armed after a narrow pulse", starts - base, 2);
        hlines(2);

        // R3: several consecutive fields
        base = starts;
        for (int k = 0; k < 3; k++) field();
        expect_int("R3 one pulse per field over three fields", starts - base, 3);

        // R6: strobe single-cycle and aligned
        expect_int("R6 strobe misalignments", r6_bad, 0);
        finish_run();
    end

endmodule